// File: doc/BRIEF.md
# Hybrid Analog/PWM Dimming Selector

This block turns a brightness request for one LED current channel into two drive quantities: a current code for the channel's current DAC and an on/off gate for that channel. At higher levels the gate stays on for the whole period and the request goes straight to the current code. Below a minimum stable current, the current code is held at that minimum and the gate is pulse-width modulated to give the rest of the dimming. The switch between the two regimes has hysteresis, so the mode does not chatter near the boundary.

Each PWM period has a fixed length in clock cycles. A new request is kept as pending and becomes active only on the first cycle of a period, so the gate and the code never change in the middle of a period. Any on-time the block produces is at least the settle time plus the sample time. A very short requested on-time is rounded down to zero or up to that minimum, and the request carries a bit that picks which. A sample-enable strobe marks the settled cycles of each on-time for the channel's open/short fault logic. From reset, the output stays dark until the first request has been committed.

Top module: `hybrid_dim_selector`

## Requirements
- R1: From reset until the first request is committed, `gate_o`, `sample_en_o` and `drive_code_o` are all 0. `period_start_o` still marks each period.
- R2: In analog mode, `drive_code_o` equals the committed level and `gate_o` is high for all PERIOD cycles of the period. `pwm_mode_o` is 0.
- R3: In PWM mode, `drive_code_o` equals I_MIN and `pwm_mode_o` is 1. `gate_o` is high for the first floor(level*PERIOD/I_MIN) cycles of the period, capped at PERIOD, and low for the remaining cycles.
- R4: Hysteresis. From analog mode, a level below I_MIN selects PWM mode. From PWM mode, only a level of at least I_MIN+HYST selects analog mode. A PWM-mode level inside [I_MIN, I_MIN+HYST) gives a full-period gate.
- R5: A computed PWM on-time between 1 and TON_MIN-1 cycles (TON_MIN = T_SETTLE+T_SAMPLE) is set to TON_MIN when `req_round_up_i` is 1 and to 0 when it is 0. A computed on-time of 0 stays 0. Any gate pulse lasts at least TON_MIN cycles.
- R6: `sample_en_o` is high on period cycles T_SETTLE to T_SETTLE+T_SAMPLE-1 (cycle 0 is the cycle with `period_start_o` high) whenever the active on-time is nonzero. It is low in every other cycle, and only ever high while `gate_o` is high.
- R7: A request takes effect only at a period boundary. `drive_code_o` keeps its old value for the rest of the current period and changes on the cycle with `period_start_o` high. `gate_o` only rises on such a cycle.
- R8: If several requests arrive before one boundary, the last of them is the one committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | One-cycle strobe that loads a new request |
| req_level_i | input | CODE_W | Requested brightness level |
| req_round_up_i | input | 1 | 1: round a short on-time up to the minimum; 0: round it down to zero |
| drive_code_o | output | CODE_W | Current code for the channel DAC |
| gate_o | output | 1 | Channel on/off gate |
| sample_en_o | output | 1 | Settled sampling window for the fault logic |
| pwm_mode_o | output | 1 | 1 in PWM mode, 0 in analog mode |
| period_start_o | output | 1 | High on the first cycle of each period |

## Verification
The assertions assume that the parameters meet I_MIN+HYST <= 2**CODE_W-1 and TON_MIN <= PERIOD. They also assume that reset is held from time zero. The level input may change on any cycle, because the design captures it only on a strobe. The bench drives each request as a single-cycle strobe at the falling edge. It uses the default parameters, and it measures results one full period after the commit, counted from the `period_start_o` cycle, so every sample it takes falls in a settled period.

// File: rtl/hds_pkg.sv
package hds_pkg;
  typedef enum logic {
    MODE_ANALOG = 1'b0,
    MODE_PWM    = 1'b1
  } dim_mode_e;
endpackage

// File: rtl/hds_period_timer.sv
module hds_period_timer #(
  parameter int PERIOD = 64,
  parameter int PER_W  = $clog2(PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PER_W-1:0] cnt_q,
  output logic [PER_W-1:0] cnt_nxt,
  output logic             wrap
);
  assign wrap    = (cnt_q == PER_W'(PERIOD - 1));
  assign cnt_nxt = wrap ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/hds_mode_select.sv
module hds_mode_select
  import hds_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int PERIOD  = 64,
  parameter int PER_W   = 7,
  parameter int I_MIN   = 32,
  parameter int HYST    = 8,
  parameter int TON_MIN = 10
) (
  input  logic [CODE_W-1:0] level,
  input  logic              round_up,
  input  dim_mode_e         cur_mode,
  output dim_mode_e         nxt_mode,
  output logic [CODE_W-1:0] code,
  output logic [PER_W-1:0]  on_time
);
  localparam int PW = CODE_W + PER_W;

  logic [CODE_W:0] lvl_w;
  logic [PW-1:0]   prod, raw;
  logic            go_pwm;

  assign lvl_w = {1'b0, level};
  assign prod  = PW'(level) * PW'(PERIOD);
  assign raw   = prod / PW'(I_MIN);

  always_comb begin
    if (cur_mode == MODE_PWM) go_pwm = (lvl_w < (CODE_W+1)'(I_MIN + HYST));
    else                      go_pwm = (lvl_w < (CODE_W+1)'(I_MIN));
    nxt_mode = go_pwm ? MODE_PWM : MODE_ANALOG;
    if (!go_pwm) begin
      code    = level;
      on_time = PER_W'(PERIOD);
    end else begin
      code = CODE_W'(I_MIN);
      if (raw >= PW'(PERIOD))       on_time = PER_W'(PERIOD);
      else if (raw == '0)           on_time = '0;
      else if (raw < PW'(TON_MIN))  on_time = round_up ? PER_W'(TON_MIN) : '0;
      else                          on_time = PER_W'(raw);
    end
  end
endmodule

// File: rtl/hybrid_dim_selector.sv
module hybrid_dim_selector
  import hds_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int PERIOD   = 64,
  parameter int I_MIN    = 32,
  parameter int HYST     = 8,
  parameter int T_SETTLE = 6,
  parameter int T_SAMPLE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [CODE_W-1:0] req_level_i,
  input  logic              req_round_up_i,
  output logic [CODE_W-1:0] drive_code_o,
  output logic              gate_o,
  output logic              sample_en_o,
  output logic              pwm_mode_o,
  output logic              period_start_o
);
  localparam int PER_W   = $clog2(PERIOD + 1);
  localparam int TON_MIN = T_SETTLE + T_SAMPLE;
  localparam int WIN_END = T_SETTLE + T_SAMPLE;

  logic [PER_W-1:0] cnt_q, cnt_nxt;
  logic             wrap;

  hds_period_timer #(.PERIOD(PERIOD), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  // pending request, overwritten by each strobe until the next boundary
  logic              pend_v_q, pend_v_nxt;
  logic [CODE_W-1:0] pend_lvl_q, pend_lvl_nxt;
  logic              pend_rnd_q, pend_rnd_nxt;

  assign pend_v_nxt   = req_valid_i | pend_v_q;
  assign pend_lvl_nxt = req_valid_i ? req_level_i : pend_lvl_q;
  assign pend_rnd_nxt = req_valid_i ? req_round_up_i : pend_rnd_q;

  // active setting
  logic              act_v_q, act_v_nxt;
  dim_mode_e         act_mode_q, act_mode_nxt, sel_mode;
  logic [CODE_W-1:0] act_code_q, act_code_nxt, sel_code;
  logic [PER_W-1:0]  act_on_q, act_on_nxt, sel_on;
  logic              commit;

  hds_mode_select #(
    .CODE_W(CODE_W), .PERIOD(PERIOD), .PER_W(PER_W),
    .I_MIN(I_MIN), .HYST(HYST), .TON_MIN(TON_MIN)
  ) u_sel (
    .level(pend_lvl_nxt), .round_up(pend_rnd_nxt), .cur_mode(act_mode_q),
    .nxt_mode(sel_mode), .code(sel_code), .on_time(sel_on)
  );

  assign commit       = wrap & pend_v_nxt;
  assign act_v_nxt    = act_v_q | commit;
  assign act_mode_nxt = commit ? sel_mode : act_mode_q;
  assign act_code_nxt = commit ? sel_code : act_code_q;
  assign act_on_nxt   = commit ? sel_on   : act_on_q;

  logic gate_nxt;
  assign gate_nxt = act_v_nxt && (cnt_nxt < act_on_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v_q       <= 1'b0;
      pend_lvl_q     <= '0;
      pend_rnd_q     <= 1'b0;
      act_v_q        <= 1'b0;
      act_mode_q     <= MODE_ANALOG;
      act_code_q     <= '0;
      act_on_q       <= '0;
      drive_code_o   <= '0;
      gate_o         <= 1'b0;
      sample_en_o    <= 1'b0;
      pwm_mode_o     <= 1'b0;
      period_start_o <= 1'b1;
    end else begin
      pend_v_q       <= wrap ? 1'b0 : pend_v_nxt;
      pend_lvl_q     <= pend_lvl_nxt;
      pend_rnd_q     <= pend_rnd_nxt;
      act_v_q        <= act_v_nxt;
      act_mode_q     <= act_mode_nxt;
      act_code_q     <= act_code_nxt;
      act_on_q       <= act_on_nxt;
      drive_code_o   <= act_v_nxt ? act_code_nxt : '0;
      gate_o         <= gate_nxt;
      sample_en_o    <= gate_nxt && (cnt_nxt >= PER_W'(T_SETTLE))
                                 && (cnt_nxt <  PER_W'(WIN_END));
      pwm_mode_o     <= (act_mode_nxt == MODE_PWM);
      period_start_o <= (cnt_nxt == '0);
    end
  end

  // ---------------- assertions ----------------
  logic [PER_W:0] hi_run_q;
  always_ff @(posedge clk) begin
    if (rst)                               hi_run_q <= '0;
    else if (!gate_o)                      hi_run_q <= '0;
    else if (hi_run_q < (PER_W+1)'(PERIOD)) hi_run_q <= hi_run_q + 1'b1;
  end

  AST_GATE_MIN_PULSE: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_o) |-> (hi_run_q >= (PER_W+1)'(TON_MIN))); // R5
  AST_SAMPLE_SETTLED: assert property (@(posedge clk) disable iff (rst)
    sample_en_o |-> (gate_o && hi_run_q >= (PER_W+1)'(T_SETTLE))); // R6
  AST_CODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$stable(drive_code_o) |-> period_start_o); // R7
  AST_GATE_RISE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> period_start_o); // R7
  AST_PWM_HOLDS_FLOOR: assert property (@(posedge clk) disable iff (rst)
    pwm_mode_o |-> (drive_code_o == CODE_W'(I_MIN))); // R3
  AST_DARK_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (drive_code_o == '0) |-> (!gate_o && !sample_en_o)); // R1
endmodule

// File: tb/test_hybrid_dim_selector.sv
module test_hybrid_dim_selector;
  localparam int CODE_W = 8;
  localparam int PERIOD = 64;
  localparam int I_MIN  = 32;
  localparam int HYST   = 8;
  localparam int T_SET  = 6;
  localparam int T_SMP  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid_i = 1'b0;
  logic [CODE_W-1:0] req_level_i = '0;
  logic              req_round_up_i = 1'b0;
  logic [CODE_W-1:0] drive_code_o;
  logic              gate_o, sample_en_o, pwm_mode_o, period_start_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  hybrid_dim_selector #(
    .CODE_W(CODE_W), .PERIOD(PERIOD), .I_MIN(I_MIN), .HYST(HYST),
    .T_SETTLE(T_SET), .T_SAMPLE(T_SMP)
  ) i_hybrid_dim_selector (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_level_i(req_level_i),
    .req_round_up_i(req_round_up_i), .drive_code_o(drive_code_o), .gate_o(gate_o),
    .sample_en_o(sample_en_o), .pwm_mode_o(pwm_mode_o), .period_start_o(period_start_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int lvl, input bit rnd);
    @(negedge clk);
    req_valid_i    = 1'b1;
    req_level_i    = CODE_W'(lvl);
    req_round_up_i = rnd;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic next_frame();
    @(negedge clk);
    while (!period_start_o) @(negedge clk);
  endtask

  // skips one period, then measures a whole period
  task automatic measure(input int e_code, input int e_on, input bit e_samp,
                         input bit e_mode, input string tag);
    int on_cnt = 0;
    int bad_pos = 0;
    int bad_code = 0;
    int bad_mode = 0;
    next_frame();
    next_frame();
    for (int i = 0; i < PERIOD; i++) begin
      if (i > 0) @(negedge clk);
      if (gate_o) on_cnt++;
      if ((gate_o != 1'b0) != (i < e_on)) bad_pos++;
      if (sample_en_o != (e_samp && i >= T_SET && i < T_SET + T_SMP)) bad_pos++;
      if (int'(drive_code_o) != e_code) bad_code++;
      if (pwm_mode_o != e_mode) bad_mode++;
    end
    check(on_cnt == e_on, {tag, " on-time"}, on_cnt, e_on);
    check(bad_pos == 0, {tag, " gate/sample placement errors"}, bad_pos, 0);
    check(bad_code == 0, {tag, " drive code"}, int'(drive_code_o), e_code);
    check(bad_mode == 0, {tag, " mode"}, int'(pwm_mode_o), int'(e_mode));
  endtask

  task automatic t_reset();
    int lit = 0;
    int frames = 0;
    for (int i = 0; i < 2 * PERIOD; i++) begin
      @(negedge clk);
      if (gate_o || sample_en_o || drive_code_o != 0) lit++;
      if (period_start_o) frames++;
    end
    check(lit == 0, "R1 dark before first commit", lit, 0);
    check(frames == 2, "R1 period strobe runs in reset state", frames, 2);
  endtask

  task automatic t_analog();
    send(200, 1'b0);
    measure(200, PERIOD, 1'b1, 1'b0, "R2 analog level 200");
    send(39, 1'b0);
    measure(39, PERIOD, 1'b1, 1'b0, "R4 analog stays analog at 39");
  endtask

  task automatic t_pwm_hyst();
    send(16, 1'b0);
    measure(I_MIN, 32, 1'b1, 1'b1, "R3 pwm level 16");
    send(31, 1'b0);
    measure(I_MIN, 62, 1'b1, 1'b1, "R3 pwm level 31");
    send(39, 1'b0);
    measure(I_MIN, PERIOD, 1'b1, 1'b1, "R4 pwm holds in band at 39");
    send(40, 1'b0);
    measure(40, PERIOD, 1'b1, 1'b0, "R4 leaves pwm at 40");
  endtask

  task automatic t_round();
    send(3, 1'b0);
    measure(I_MIN, 0, 1'b0, 1'b1, "R5 short on-time rounded down");
    send(3, 1'b1);
    measure(I_MIN, 10, 1'b1, 1'b1, "R5 short on-time rounded up");
    send(4, 1'b1);
    measure(I_MIN, 10, 1'b1, 1'b1, "R5 eight cycles rounded up");
    send(5, 1'b0);
    measure(I_MIN, 10, 1'b1, 1'b1, "R5 exact minimum kept");
    send(0, 1'b1);
    measure(I_MIN, 0, 1'b0, 1'b1, "R6 zero level, no window");
  endtask

  task automatic t_boundary();
    send(200, 1'b0);
    measure(200, PERIOD, 1'b1, 1'b0, "R7 setup level 200");
    next_frame();
    repeat (5) @(negedge clk);
    send(100, 1'b0);
    check(drive_code_o == 200, "R7 code unchanged mid-period", int'(drive_code_o), 200);
    next_frame();
    check(drive_code_o == 100, "R7 code changes at period start", int'(drive_code_o), 100);
  endtask

  task automatic t_last_wins();
    next_frame();
    repeat (3) @(negedge clk);
    send(50, 1'b0);
    send(70, 1'b0);
    measure(70, PERIOD, 1'b1, 1'b0, "R8 last request committed");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_analog();
    t_pwm_hyst();
    t_round();
    t_boundary();
    t_last_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule